// File: doc/BRIEF.md
# Class-Indexed Moore Sequencing Controller

This block is a sixteen-state Moore sequencer for a control unit. A 4-bit state register addresses a read-only word table. Each word carries the thirteen microoperation strobes for that state. It also carries a 3-bit code that names the state's group of pseudoequivalent states, meaning states whose exits are identical for every flag combination.

The next-state logic never decodes the full state code. It sees only the group code taken from the spare word bits and the six condition flags. As a result it holds 18 condition/next-state entries instead of the 45 a per-state table would need. The strobes and the group code are exposed, together with the state code, so a sequencer trace can be followed from outside.

A start pulse or a synchronous reset places the machine in its first state. From then on the state moves once per rising clock edge.

Top module: `mcc_controller`

## Requirements
- R1: On a rising clock edge where `rst` or `start` (or both) is high, the state code becomes 0000 (the first state); no other event alters the state outside a rising clock edge.
- R2: The states S1..S16 have the plain binary codes 0..15 on `state_code` (S1 = 0000, S16 = 1111).
- R3: `ops[n-1]` carries strobe yn. Active strobes per state: S1 none; S2 y1 y2; S3 y2 y3; S4 y4; S5 y3 y5 y7; S6 y1 y2; S7 y4; S8 y6 y7 y8; S9 y3 y9 y11; S10 y2 y3; S11 y3 y5 y7; S12 y3 y9 y11; S13 y1 y9 y10; S14 y9 y12; S15 y3 y13; S16 y4.
- R4: `group_code` gives the state's group: G0 (000) = {S1}; G1 (001) = {S2,S3,S4}; G2 (010) = {S5,S6,S7}; G3 (011) = {S8,S9,S10}; G4 (100) = {S11,S12,S13}; G5 (101) = {S14,S15}; G6 (110) = {S16}. The code 111 never appears.
- R5: In group G0, with `flags[k-1]` = xk: x1 and x2 go to S2; x1 and not x2 go to S3; not x1 goes to S4.
- R6: In group G1: x2 and x3 go to S5; x2 and not x3 go to S6; not x2 and x4 go to S7; not x2 and not x4 go to S4.
- R7: In group G2: x1 and x5 go to S8; x1 and not x5 go to S9; not x1 goes to S10.
- R8: In group G3: x3 and x4 go to S11; x3 and not x4 go to S12; not x3 and x6 go to S13; not x3 and not x6 go to S16.
- R9: In group G4, x4 goes to S14 and not x4 goes to S15. G5 always goes to S16. G6 always goes to S1.
- R10: `ops` and `group_code` depend on the state alone; a change of `flags` between clock edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to S1 |
| start | input | 1 | Synchronous start pulse, loads S1 |
| flags | input | 6 | Condition flags, bit k-1 is xk |
| ops | output | 13 | Microoperation strobes, bit n-1 is yn |
| group_code | output | 3 | Group code of the current state (debug) |
| state_code | output | 4 | Current state code (debug) |

## Verification
Long runs of random flag vectors send the machine through every group and every branch. Each cycle's state is compared with a model built from a per-state table, so a wrong group entry in the word table shows up as a wrong exit from one particular state. Occasional start pulses, and a cycle with reset and start high together, separate the load path from the normal transitions. Flag changes applied in mid-cycle separate a true Moore output from one that leaks combinationally from the flags.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int STATE_W   = 4;
    localparam int GROUP_W   = 3;
    localparam int OPS_N     = 13;
    localparam int FLAGS_N   = 6;
    localparam int SLICE_W   = 4;
    localparam int WORD_W    = OPS_N + GROUP_W;
    localparam int SLICES    = WORD_W / SLICE_W;
    localparam int NUM_STATES = 1 << STATE_W;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [OPS_N-1:0]   ops_t;
    typedef logic [FLAGS_N-1:0] flags_t;

    typedef enum logic [GROUP_W-1:0] {
        GRP_ENTRY  = 3'd0,
        GRP_FORK   = 3'd1,
        GRP_SPLIT  = 3'd2,
        GRP_TEST   = 3'd3,
        GRP_MERGE  = 3'd4,
        GRP_DRAIN  = 3'd5,
        GRP_RETURN = 3'd6,
        GRP_BAD    = 3'd7
    } group_e;

    typedef struct packed {
        group_e grp;
        ops_t   ops;
    } word_t;

    localparam state_t HOME_STATE = '0;

    function automatic ops_t strobe(input int n);
        ops_t v;
        v = '0;
        v[n-1] = 1'b1;
        return v;
    endfunction

    function automatic ops_t ops_of(input state_t s);
        ops_t v;
        case (s)
            4'd0:  v = '0;
            4'd1:  v = strobe(1) | strobe(2);
            4'd2:  v = strobe(2) | strobe(3);
            4'd3:  v = strobe(4);
            4'd4:  v = strobe(3) | strobe(5) | strobe(7);
            4'd5:  v = strobe(1) | strobe(2);
            4'd6:  v = strobe(4);
            4'd7:  v = strobe(6) | strobe(7) | strobe(8);
            4'd8:  v = strobe(3) | strobe(9) | strobe(11);
            4'd9:  v = strobe(2) | strobe(3);
            4'd10: v = strobe(3) | strobe(5) | strobe(7);
            4'd11: v = strobe(3) | strobe(9) | strobe(11);
            4'd12: v = strobe(1) | strobe(9) | strobe(10);
            4'd13: v = strobe(9) | strobe(12);
            4'd14: v = strobe(3) | strobe(13);
            default: v = strobe(4);
        endcase
        return v;
    endfunction

    function automatic group_e group_of(input state_t s);
        group_e g;
        if (s == 4'd0)       g = GRP_ENTRY;
        else if (s <= 4'd3)  g = GRP_FORK;
        else if (s <= 4'd6)  g = GRP_SPLIT;
        else if (s <= 4'd9)  g = GRP_TEST;
        else if (s <= 4'd12) g = GRP_MERGE;
        else if (s <= 4'd14) g = GRP_DRAIN;
        else                 g = GRP_RETURN;
        return g;
    endfunction

    function automatic logic [WORD_W-1:0] word_image(input state_t s);
        word_t w;
        w.grp = group_of(s);
        w.ops = ops_of(s);
        return w;
    endfunction

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  state_t next_state,
    output state_t state
);
    always_ff @(posedge clk) begin
        if (rst || start) state <= HOME_STATE;
        else              state <= next_state;
    end
endmodule

// File: rtl/mcc_word_rom.sv
module mcc_word_rom
    import mcc_pkg::*;
(
    input  state_t addr,
    output word_t  word
);
    logic [WORD_W-1:0] flat;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        logic [SLICE_W-1:0] slice_q;
        always_comb begin
            logic [WORD_W-1:0] img;
            img     = word_image(addr);
            slice_q = img[s*SLICE_W +: SLICE_W];
        end
        assign flat[s*SLICE_W +: SLICE_W] = slice_q;
    end

    assign word = word_t'(flat);
endmodule

// File: rtl/mcc_group_next.sv
module mcc_group_next
    import mcc_pkg::*;
(
    input  group_e grp,
    input  flags_t flags,
    output state_t next_state
);
    logic x1, x2, x3, x4, x5, x6;
    assign {x6, x5, x4, x3, x2, x1} = flags;

    always_comb begin
        unique case (grp)
            GRP_ENTRY:  next_state = x1 ? (x2 ? 4'd1 : 4'd2) : 4'd3;
            GRP_FORK:   next_state = x2 ? (x3 ? 4'd4 : 4'd5)
                                        : (x4 ? 4'd6 : 4'd3);
            GRP_SPLIT:  next_state = x1 ? (x5 ? 4'd7 : 4'd8) : 4'd9;
            GRP_TEST:   next_state = x3 ? (x4 ? 4'd10 : 4'd11)
                                        : (x6 ? 4'd12 : 4'd15);
            GRP_MERGE:  next_state = x4 ? 4'd13 : 4'd14;
            GRP_DRAIN:  next_state = 4'd15;
            GRP_RETURN: next_state = HOME_STATE;
            default:    next_state = HOME_STATE;
        endcase
    end
endmodule

// File: rtl/mcc_controller.sv
module mcc_controller
    import mcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FLAGS_N-1:0] flags,
    output logic [OPS_N-1:0]   ops,
    output logic [GROUP_W-1:0] group_code,
    output logic [STATE_W-1:0] state_code
);
    state_t state_q;
    state_t next_d;
    word_t  word;

    mcc_state_reg i_reg (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .next_state (next_d),
        .state      (state_q)
    );

    mcc_word_rom i_rom (
        .addr (state_q),
        .word (word)
    );

    mcc_group_next i_next (
        .grp        (word.grp),
        .flags      (flags),
        .next_state (next_d)
    );

    assign ops        = word.ops;
    assign group_code = word.grp;
    assign state_code = state_q;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [12:0] ops,
    input logic [2:0] group_code,
    input logic [3:0] state_code
);
    assert_start_home_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> state_code == 4'd0);

    assert_home_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        state_code == 4'd0 |-> ops == 13'd0);

    assert_group_valid_R4: assert property (@(posedge clk) disable iff (rst)
        group_code != 3'd7);

    assert_fork_group_R4: assert property (@(posedge clk) disable iff (rst)
        (state_code >= 4'd1 && state_code <= 4'd3) |-> group_code == 3'd1);

    assert_entry_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (group_code == 3'd0 && !start) |=>
            (state_code >= 4'd1 && state_code <= 4'd3));

    assert_merge_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (group_code == 3'd4 && !start) |=>
            (state_code == 4'd13 || state_code == 4'd14));

    assert_drain_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (group_code == 3'd5 && !start) |=> state_code == 4'd15);

    assert_return_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (group_code == 3'd6) |=> state_code == 4'd0);
endmodule

bind mcc_controller mcc_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ops        (ops),
    .group_code (group_code),
    .state_code (state_code)
);

// File: tb/test_mcc_controller.sv
module test_mcc_controller;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  flags = '0;
    logic [12:0] ops;
    logic [2:0]  group_code;
    logic [3:0]  state_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mcc_controller i_mcc_controller (
        .clk(clk), .rst(rst), .start(start), .flags(flags),
        .ops(ops), .group_code(group_code), .state_code(state_code)
    );

    typedef struct { logic [3:0] st; int tag; } item_t;
    item_t exp_q[$];
    logic [3:0] m_state = 4'd0;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    // per-state reference table (R5..R9)
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] f);
        case (s)
            4'd0:                return f[0] ? (f[1] ? 4'd1 : 4'd2) : 4'd3;
            4'd1, 4'd2, 4'd3:    return f[1] ? (f[2] ? 4'd4 : 4'd5) : (f[3] ? 4'd6 : 4'd3);
            4'd4, 4'd5, 4'd6:    return f[0] ? (f[4] ? 4'd7 : 4'd8) : 4'd9;
            4'd7, 4'd8, 4'd9:    return f[2] ? (f[3] ? 4'd10 : 4'd11) : (f[5] ? 4'd12 : 4'd15);
            4'd10, 4'd11, 4'd12: return f[3] ? 4'd13 : 4'd14;
            4'd13, 4'd14:        return 4'd15;
            default:             return 4'd0;
        endcase
    endfunction

    function automatic int ref_tag(input logic [3:0] s);
        if (s == 0) return 5;
        if (s <= 3) return 6;
        if (s <= 6) return 7;
        if (s <= 9) return 8;
        return 9;
    endfunction

    function automatic logic [12:0] y(input int n);
        return 13'd1 << (n - 1);
    endfunction

    function automatic logic [12:0] ref_ops(input logic [3:0] s);
        case (s)
            4'd0:  return '0;
            4'd1:  return y(1) | y(2);
            4'd2:  return y(2) | y(3);
            4'd3:  return y(4);
            4'd4:  return y(3) | y(5) | y(7);
            4'd5:  return y(1) | y(2);
            4'd6:  return y(4);
            4'd7:  return y(6) | y(7) | y(8);
            4'd8:  return y(3) | y(9) | y(11);
            4'd9:  return y(2) | y(3);
            4'd10: return y(3) | y(5) | y(7);
            4'd11: return y(3) | y(9) | y(11);
            4'd12: return y(1) | y(9) | y(10);
            4'd13: return y(9) | y(12);
            4'd14: return y(3) | y(13);
            default: return y(4);
        endcase
    endfunction

    function automatic logic [2:0] ref_group(input logic [3:0] s);
        case (s)
            4'd0: return 3'd0;
            4'd1, 4'd2, 4'd3: return 3'd1;
            4'd4, 4'd5, 4'd6: return 3'd2;
            4'd7, 4'd8, 4'd9: return 3'd3;
            4'd10, 4'd11, 4'd12: return 3'd4;
            4'd13, 4'd14: return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: one clock cycle per call, pushes the expected post-edge state
    task automatic step(input bit r, input bit s, input logic [5:0] f);
        item_t it;
        logic [12:0] ops_before;
        logic [2:0]  grp_before;
        @(negedge clk);
        ops_before = ops;
        grp_before = group_code;
        rst = r; start = s; flags = f;
        #1;
        if (!done && exp_q.size() == 0 && m_state !== 4'bx) begin
            // R10: mid-cycle flag change leaves Moore outputs unchanged
            check(ops === ops_before, "R10", "ops", ops, ops_before);
            check(group_code === grp_before, "R10", "group", group_code, grp_before);
        end
        if (r || s) begin it.st = 4'd0; it.tag = 1; end
        else begin it.st = ref_next(m_state, f); it.tag = ref_tag(m_state); end
        m_state = it.st;
        exp_q.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(state_code === it.st, tag_name(it.tag), "state", state_code, it.st);
                // R2: the state code is plain binary, checked through per-state tables
                check(ops === ref_ops(it.st), "R3", "ops", ops, ref_ops(it.st));
                check(group_code === ref_group(it.st), "R4", "group", group_code, ref_group(it.st));
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(1, 0, 6'd0);   // R1 reset state
        step(1, 0, 6'd0);
        // directed walk: S1 -> S2 -> S5 -> S8 -> S11 -> S14 -> S16 -> S1
        step(0, 0, 6'b000011);
        step(0, 0, 6'b000110);
        step(0, 0, 6'b010001);
        step(0, 0, 6'b001100);
        step(0, 0, 6'b001000);
        step(0, 0, 6'd0);
        step(0, 0, 6'd0);
        // R1 with reset and start together, then start alone
        step(0, 0, 6'b000001);
        step(1, 1, 6'b111111);
        step(0, 0, 6'b000000);
        step(0, 1, 6'b101010);
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] f;
            bit s, r;
            f = 6'($urandom);
            s = ($urandom % 40) == 0;
            r = ($urandom % 200) == 0;
            step(r, s, f);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule